// File: doc/BRIEF.md
# Single-Accumulator Processor with Step Sequencer

This block is a compact processor built around one 16-bit accumulator, a 1-bit extend flag and a 12-bit program counter. Its 4096-word, 16-bit, word-addressed store sits inside the block. Each instruction runs as a series of register transfers. A 4-bit step counter feeds a 4-to-16 decoder, and the one active step line selects which transfers happen in a given clock. All transfers that share a guard fire on the same edge. A multiplexer-based shared bus carries the value that a step moves.

In use, a test environment holds reset and writes a program and its data through the preload port. It then releases reset and watches the program counter, the accumulator, the extend flag and the halt flag. The halt flag rises when the program reaches its halt instruction.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the block clears the program counter, the accumulator, the extend flag, the halt flag and the step counter. The first edge after release runs step 0 of the instruction at address 0.
- R2: While the block is not halted, exactly one of the sixteen step lines is active in each clock period.
- R3: An instruction word holds the indirect flag in bit 15, the opcode in bits 14:12 and an address or operation-select field in bits 11:0. The opcodes are 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 6 ISZ and 7 register-reference. Opcode 5 does nothing.
- R4: Fetch runs over three steps. Step 0 copies PC to AR. Step 1 loads the word at AR into IR and increments PC. Step 2 copies IR bits 11:0 to AR and latches the indirect flag.
- R5: For a memory-reference instruction with bit 15 set, step 3 replaces AR with the low 12 bits of the word at AR. This makes the operand address indirect.
- R6: AND and LDA set AC to AC AND M[EA] and to M[EA], respectively. ADD sets AC to the low 16 bits of AC+M[EA] and E to the carry out.
- R7: STA writes AC to M[EA]. ISZ writes M[EA]+1 back to M[EA], and when that result is 0 it also increments PC once more, which skips the next instruction.
- R8: BUN loads PC with the effective address, so execution continues at that address.
- R9: Register-reference select bits 11, 10, 9, 8 and 5 give CLA (AC=0), CLE (E=0), CMA (AC inverted), CME (E inverted) and INC (AC+1 with E unchanged).
- R10: Select bit 7 (CIR) rotates {AC,E} right on one edge: AC[15] takes E, AC[14:0] takes AC[15:1], and E takes the old AC[0]. Select bit 6 (CIL) rotates left: AC takes {AC[14:0],E} and E takes the old AC[15].
- R11: Select bit 0 (HLT) sets the halt flag. From then on PC, AC, E and the halt flag stay unchanged until reset.
- R12: A write on the preload port (`ld_en` high at an edge) stores `ld_data` at `ld_addr`, and instructions then read that word.
- R13: Each instruction clears the step counter when it finishes. A register-reference instruction takes 4 clocks, STA and BUN take 5, AND, ADD and LDA take 6, and ISZ takes 7. The next instruction's step 0 follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word value |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extend (carry) flag |
| halt_o | output | 1 | Halt flag |

## Verification
Short programs each target one group of instructions. Every program ends in a halt, and its final PC, AC and E are compared with values worked out by hand. The operands are chosen so that a wrong transfer cannot land on the right answer. An ADD with a carry out sets E, and a following AND keeps only one bit of the sum. Indirect loads and stores go through pointer words that differ from the direct addresses, so a missed indirection reads a different word. A branch jumps over a halt that a fall-through would reach. Two ISZ operations, one that does not wrap and one that wraps, tell the skip apart from a plain increment. A rotate chain that feeds E back in gives a final AC and E that no single missing or reversed rotate can produce. One program's halt cycle is checked against the summed instruction lengths, and the outputs are watched for drift after a halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [2:0] {
      BUS_ZERO = 3'd0,
      BUS_AR   = 3'd1,
      BUS_PC   = 3'd2,
      BUS_DR   = 3'd3,
      BUS_AC   = 3'd4,
      BUS_IR   = 3'd5,
      BUS_MEM  = 3'd6
   } bus_sel_e;

   localparam int BUS_SRCS = 7;

   typedef enum logic [3:0] {
      ALU_HOLD,
      ALU_AND,
      ALU_ADD,
      ALU_LOAD,
      ALU_CLA,
      ALU_CLE,
      ALU_CMA,
      ALU_CME,
      ALU_CIR,
      ALU_CIL,
      ALU_INC
   } alu_op_e;

   localparam int OP_AND = 0;
   localparam int OP_ADD = 1;
   localparam int OP_LDA = 2;
   localparam int OP_STA = 3;
   localparam int OP_BUN = 4;
   localparam int OP_NOP = 5;
   localparam int OP_ISZ = 6;
   localparam int OP_REG = 7;

endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
   parameter int SC_W = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  run,
   input  logic                  clr,
   output logic [(1<<SC_W)-1:0]  t_o
);
   localparam int NT = 1 << SC_W;

   logic [SC_W-1:0] sc;

   always_ff @(posedge clk) begin
      if (rst) begin
         sc <= '0;
      end else if (run) begin
         if (clr) sc <= '0;
         else     sc <= sc + 1'b1;
      end
   end

   for (genvar g = 0; g < NT; g++) begin : g_step
      assign t_o[g] = run && (sc == SC_W'(g));
   end

   // R2: while running, one step line and only one
   p_one_step_r2 : assert property (@(posedge clk) disable iff (rst)
      run |-> ($countones(t_o) == 1));

endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
   parameter int W = 16,
   parameter int N = 7
) (
   input  logic [N-1:0][W-1:0]      src_i,
   input  logic [$clog2(N)-1:0]     sel_i,
   output logic [W-1:0]             bus_o
);
   localparam int SEL_W = $clog2(N);

   logic [N-1:0][W-1:0] gated;

   for (genvar g = 0; g < N; g++) begin : g_leg
      assign gated[g] = (sel_i == SEL_W'(g)) ? src_i[g] : '0;
   end

   always_comb begin
      bus_o = '0;
      for (int k = 0; k < N; k++) bus_o = bus_o | gated[k];
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e             op_i,
   input  logic [DATA_W-1:0]   ac_i,
   input  logic                e_i,
   input  logic [DATA_W-1:0]   dr_i,
   output logic [DATA_W-1:0]   ac_o,
   output logic                e_o
);
   always_comb begin
      ac_o = ac_i;
      e_o  = e_i;
      unique case (op_i)
         ALU_AND:  ac_o = ac_i & dr_i;
         ALU_ADD:  {e_o, ac_o} = {1'b0, ac_i} + {1'b0, dr_i};
         ALU_LOAD: ac_o = dr_i;
         ALU_CLA:  ac_o = '0;
         ALU_CLE:  e_o = 1'b0;
         ALU_CMA:  ac_o = ~ac_i;
         ALU_CME:  e_o = ~e_i;
         ALU_CIR:  begin ac_o = {e_i, ac_i[DATA_W-1:1]}; e_o = ac_i[0]; end
         ALU_CIL:  begin ac_o = {ac_i[DATA_W-2:0], e_i}; e_o = ac_i[DATA_W-1]; end
         ALU_INC:  ac_o = ac_i + 1'b1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16,
   parameter int SC_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] ac_o,
   output logic              e_o,
   output logic              halt_o
);
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int NT      = 1 << SC_W;
   localparam int IND_BIT = DATA_W - 1;
   localparam int OPC_LSB = ADDR_W;
   localparam int SEL_W   = $clog2(BUS_SRCS);

   if (DATA_W != ADDR_W + 4) begin : g_bad_fmt
      $error("acc_cpu: DATA_W must equal ADDR_W + 4");
   end
   if (ADDR_W < 12 || ADDR_W > 13) begin : g_bad_addr
      $error("acc_cpu: ADDR_W must be 12 or 13");
   end
   if (SC_W < 3) begin : g_bad_sc
      $error("acc_cpu: SC_W must be at least 3");
   end

   logic [ADDR_W-1:0] ar, pc;
   logic [DATA_W-1:0] ir, dr, ac;
   logic              e, ind, halt;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] mem_rd, bus;
   logic [NT-1:0]     t;
   logic [7:0]        dop;
   logic [2:0]        opc;
   logic [11:0]       rr;
   logic              late, rr_go;

   bus_sel_e bus_sel;
   alu_op_e  alu_op;
   logic ar_ld, pc_ld, pc_inc, ir_ld, dr_ld, dr_inc, mem_we, ind_ld, sc_clr, halt_set;
   logic [DATA_W-1:0] ac_nx;
   logic              e_nx;
   logic [BUS_SRCS-1:0][DATA_W-1:0] src;

   acc_seq_timer #(.SC_W(SC_W)) u_seq (
      .clk (clk),
      .rst (rst),
      .run (!halt),
      .clr (sc_clr),
      .t_o (t)
   );

   assign src[BUS_ZERO] = '0;
   assign src[BUS_AR]   = {{(DATA_W-ADDR_W){1'b0}}, ar};
   assign src[BUS_PC]   = {{(DATA_W-ADDR_W){1'b0}}, pc};
   assign src[BUS_DR]   = dr;
   assign src[BUS_AC]   = ac;
   assign src[BUS_IR]   = ir;
   assign src[BUS_MEM]  = mem_rd;

   acc_bus_mux #(.W(DATA_W), .N(BUS_SRCS)) u_bus (
      .src_i (src),
      .sel_i (SEL_W'(bus_sel)),
      .bus_o (bus)
   );

   acc_alu #(.DATA_W(DATA_W)) u_alu (
      .op_i (alu_op),
      .ac_i (ac),
      .e_i  (e),
      .dr_i (dr),
      .ac_o (ac_nx),
      .e_o  (e_nx)
   );

   assign mem_rd = mem[ar];
   assign opc    = ir[OPC_LSB +: 3];
   assign rr     = ir[11:0];
   assign late   = |t[NT-1:7];
   assign rr_go  = t[3] && dop[OP_REG] && !ind;

   for (genvar g = 0; g < 8; g++) begin : g_opdec
      assign dop[g] = (opc == 3'(g));
   end

   always_comb begin
      bus_sel  = BUS_ZERO;
      alu_op   = ALU_HOLD;
      ar_ld    = 1'b0;
      pc_ld    = 1'b0;
      pc_inc   = 1'b0;
      ir_ld    = 1'b0;
      dr_ld    = 1'b0;
      dr_inc   = 1'b0;
      mem_we   = 1'b0;
      ind_ld   = 1'b0;
      sc_clr   = 1'b0;
      halt_set = 1'b0;
      if (t[0]) begin
         bus_sel = BUS_PC;  ar_ld = 1'b1;
      end
      if (t[1]) begin
         bus_sel = BUS_MEM; ir_ld = 1'b1; pc_inc = 1'b1;
      end
      if (t[2]) begin
         bus_sel = BUS_IR;  ar_ld = 1'b1; ind_ld = 1'b1;
      end
      if (t[3]) begin
         if (dop[OP_REG]) begin
            sc_clr = 1'b1;
            if (!ind) begin
               priority casez (rr)
                  12'b1???????????: alu_op = ALU_CLA;
                  12'b01??????????: alu_op = ALU_CLE;
                  12'b001?????????: alu_op = ALU_CMA;
                  12'b0001????????: alu_op = ALU_CME;
                  12'b00001???????: alu_op = ALU_CIR;
                  12'b000001??????: alu_op = ALU_CIL;
                  12'b0000001?????: alu_op = ALU_INC;
                  default:          alu_op = ALU_HOLD;
               endcase
               halt_set = rr[0];
            end
         end else if (ind) begin
            bus_sel = BUS_MEM; ar_ld = 1'b1;
         end
      end
      if (t[4] && !dop[OP_REG]) begin
         if (dop[OP_STA]) begin
            bus_sel = BUS_AC; mem_we = 1'b1; sc_clr = 1'b1;
         end else if (dop[OP_BUN]) begin
            bus_sel = BUS_AR; pc_ld = 1'b1; sc_clr = 1'b1;
         end else if (dop[OP_NOP]) begin
            sc_clr = 1'b1;
         end else begin
            bus_sel = BUS_MEM; dr_ld = 1'b1;
         end
      end
      if (t[5]) begin
         if (dop[OP_AND]) begin alu_op = ALU_AND;  sc_clr = 1'b1; end
         if (dop[OP_ADD]) begin alu_op = ALU_ADD;  sc_clr = 1'b1; end
         if (dop[OP_LDA]) begin alu_op = ALU_LOAD; sc_clr = 1'b1; end
         if (dop[OP_ISZ]) dr_inc = 1'b1;
      end
      if (t[6] && dop[OP_ISZ]) begin
         bus_sel = BUS_DR; mem_we = 1'b1; sc_clr = 1'b1;
         pc_inc  = (dr == '0);
      end
      if (late) sc_clr = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ar   <= '0;
         pc   <= '0;
         ir   <= '0;
         dr   <= '0;
         ac   <= '0;
         e    <= 1'b0;
         ind  <= 1'b0;
         halt <= 1'b0;
      end else begin
         if (ar_ld) ar <= bus[ADDR_W-1:0];
         if (pc_ld)       pc <= bus[ADDR_W-1:0];
         else if (pc_inc) pc <= pc + 1'b1;
         if (ir_ld) ir <= bus;
         if (dr_ld)       dr <= bus;
         else if (dr_inc) dr <= dr + 1'b1;
         if (alu_op != ALU_HOLD) begin
            ac <= ac_nx;
            e  <= e_nx;
         end
         if (ind_ld)   ind  <= ir[IND_BIT];
         if (halt_set) halt <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ld_en)       mem[ld_addr] <= ld_data;
      else if (mem_we) mem[ar]      <= bus;
   end

   assign pc_o   = pc;
   assign ac_o   = ac;
   assign e_o    = e;
   assign halt_o = halt;

   // R1: reset leaves the visible state cleared
   p_reset_clear_r1 : assert property (@(posedge clk)
      rst |=> (pc == '0 && ac == '0 && !e && !halt));

   // R4: fetch step 1 advances PC by one
   p_fetch_inc_r4 : assert property (@(posedge clk) disable iff (rst)
      t[1] |=> (pc == $past(pc) + 1'b1));

   // R5: indirect step swaps AR for the pointer word
   p_indirect_r5 : assert property (@(posedge clk) disable iff (rst)
      (t[3] && !dop[OP_REG] && ind) |=> (ar == $past(mem_rd[ADDR_W-1:0])));

   // R6: add produces carry into E
   p_add_carry_r6 : assert property (@(posedge clk) disable iff (rst)
      (t[5] && dop[OP_ADD]) |=> ({e, ac} == ({1'b0, $past(ac)} + {1'b0, $past(dr)})));

   // R7: ISZ skip when the incremented word is zero
   p_isz_skip_r7 : assert property (@(posedge clk) disable iff (rst)
      (t[6] && dop[OP_ISZ] && dr == '0) |=> (pc == $past(pc) + 1'b1));

   // R8: branch target lands in PC
   p_branch_r8 : assert property (@(posedge clk) disable iff (rst)
      (t[4] && dop[OP_BUN]) |=> (pc == $past(ar)));

   // R10: rotate right through E in one edge
   p_rotate_right_r10 : assert property (@(posedge clk) disable iff (rst)
      (rr_go && rr == 12'h080) |=> (ac == {$past(e), $past(ac[DATA_W-1:1])} && e == $past(ac[0])));

   // R11: halted state is frozen
   p_halt_freeze_r11 : assert property (@(posedge clk) disable iff (rst)
      halt |=> ($stable(pc) && $stable(ac) && $stable(e) && halt));

   // R13: a register-reference instruction restarts at step 0 (or halts)
   p_regref_len_r13 : assert property (@(posedge clk) disable iff (rst)
      rr_go |=> (t[0] || halt));

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic [11:0] ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [11:0] pc_o;
   logic [15:0] ac_o;
   logic        e_o;
   logic        halt_o;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      string       req;
      logic [11:0] pc;
      logic [15:0] ac;
      logic        e;
   } exp_t;

   typedef struct {
      logic [11:0] a;
      logic [15:0] d;
   } ld_t;

   exp_t sb[$];
   ld_t  ldq[$];

   always #10 clk = ~clk;

   acc_cpu u0 (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .pc_o    (pc_o),
      .ac_o    (ac_o),
      .e_o     (e_o),
      .halt_o  (halt_o)
   );

   localparam logic [15:0] I_CLA = 16'h7800;
   localparam logic [15:0] I_CLE = 16'h7400;
   localparam logic [15:0] I_CMA = 16'h7200;
   localparam logic [15:0] I_CME = 16'h7100;
   localparam logic [15:0] I_CIR = 16'h7080;
   localparam logic [15:0] I_CIL = 16'h7040;
   localparam logic [15:0] I_INC = 16'h7020;
   localparam logic [15:0] I_HLT = 16'h7001;

   function automatic logic [15:0] mk(input logic ib, input logic [2:0] op, input logic [11:0] a);
      return {ib, op, a};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [11:0] a, input logic [15:0] d);
      ldq.push_back('{a: a, d: d});
   endtask

   task automatic run_prog(input string req, input logic [11:0] pc, input logic [15:0] ac,
                           input logic e, input int cyc);
      rst = 1'b1;
      @(negedge clk);
      foreach (ldq[k]) begin
         ld_en   = 1'b1;
         ld_addr = ldq[k].a;
         ld_data = ldq[k].d;
         @(negedge clk);
      end
      ld_en = 1'b0;
      ldq.delete();
      sb.push_back('{req: req, pc: pc, ac: ac, e: e});
      @(negedge clk);
      rst = 1'b0;
      if (cyc > 0) begin
         repeat (cyc - 1) @(posedge clk);
         @(negedge clk);
         chk("R13", "halt one clock early", int'(halt_o), 0);
         @(posedge clk);
         @(negedge clk);
         chk("R13", "halt at summed length", int'(halt_o), 1);
      end
      while (!halt_o) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: pops an expected item on each rising halt
   initial begin
      bit   prev = 1'b0;
      exp_t it;
      forever begin
         @(negedge clk);
         if (rst) prev = 1'b0;
         else if (halt_o && !prev) begin
            prev = 1'b1;
            if (sb.size() == 0) chk("R11", "unexpected halt", 1, 0);
            else begin
               it = sb.pop_front();
               chk(it.req, "PC", int'(pc_o), int'(it.pc));
               chk(it.req, "AC", int'(ac_o), int'(it.ac));
               chk(it.req, "E",  int'(e_o),  int'(it.e));
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL R13 watchdog: actual hung expected halt");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [11:0] fpc;
      logic [15:0] fac;
      logic        fe;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "PC after reset", int'(pc_o), 0);
      chk("R1", "AC after reset", int'(ac_o), 0);
      chk("R1", "E after reset", int'(e_o), 0);
      chk("R1", "halt after reset", int'(halt_o), 0);

      // R6 R3 R12 R13: LDA, ADD with carry, AND; 6+6+6+4 clocks
      put(12'h000, mk(0, 3'd2, 12'h100));
      put(12'h001, mk(0, 3'd1, 12'h101));
      put(12'h002, mk(0, 3'd0, 12'h102));
      put(12'h003, I_HLT);
      put(12'h100, 16'h8001);
      put(12'h101, 16'h8002);
      put(12'h102, 16'h0002);
      run_prog("R6 arith", 12'h004, 16'h0002, 1'b1, 22);

      // R5 R7: indirect load and indirect store
      put(12'h000, mk(1, 3'd2, 12'h200));
      put(12'h001, mk(1, 3'd3, 12'h201));
      put(12'h002, I_CLA);
      put(12'h003, mk(0, 3'd2, 12'h230));
      put(12'h004, I_HLT);
      put(12'h200, 16'h0210);
      put(12'h210, 16'h1234);
      put(12'h201, 16'h0230);
      put(12'h230, 16'h0000);
      run_prog("R5 indirect", 12'h005, 16'h1234, 1'b0, 0);

      // R7 R12: direct store then reload
      put(12'h000, mk(0, 3'd2, 12'h240));
      put(12'h001, mk(0, 3'd3, 12'h241));
      put(12'h002, I_CLA);
      put(12'h003, mk(0, 3'd2, 12'h241));
      put(12'h004, I_HLT);
      put(12'h240, 16'h5A5A);
      put(12'h241, 16'h0000);
      run_prog("R7 store", 12'h005, 16'h5A5A, 1'b0, 0);

      // R8: direct and indirect branch over a halt
      put(12'h000, mk(0, 3'd4, 12'h010));
      put(12'h001, I_HLT);
      put(12'h010, mk(1, 3'd4, 12'h300));
      put(12'h300, 16'h0020);
      put(12'h020, I_CLA);
      put(12'h021, I_CMA);
      put(12'h022, I_HLT);
      run_prog("R8 branch", 12'h023, 16'hFFFF, 1'b0, 0);

      // R7: ISZ without wrap, then with wrap and skip
      put(12'h000, mk(0, 3'd6, 12'h400));
      put(12'h001, mk(0, 3'd6, 12'h400));
      put(12'h002, I_HLT);
      put(12'h003, mk(0, 3'd2, 12'h400));
      put(12'h004, I_HLT);
      put(12'h400, 16'hFFFE);
      run_prog("R7 isz", 12'h005, 16'h0000, 1'b0, 0);

      // R9: CLA CMA INC (E kept) CME INC
      put(12'h000, I_CLA);
      put(12'h001, I_CMA);
      put(12'h002, I_INC);
      put(12'h003, I_CME);
      put(12'h004, I_INC);
      put(12'h005, I_HLT);
      run_prog("R9 regops", 12'h006, 16'h0001, 1'b1, 0);

      // R9: CME then CLE, CMA
      put(12'h000, I_CME);
      put(12'h001, I_CLE);
      put(12'h002, I_CMA);
      put(12'h003, I_HLT);
      run_prog("R9 clear E", 12'h004, 16'hFFFF, 1'b0, 0);

      // R10: rotate chain 8001 -> CIR 4000/1 -> CIR A000/0 -> CIL 4000/1
      put(12'h000, mk(0, 3'd2, 12'h500));
      put(12'h001, I_CIR);
      put(12'h002, I_CIR);
      put(12'h003, I_CIL);
      put(12'h004, I_HLT);
      put(12'h500, 16'h8001);
      run_prog("R10 rotate", 12'h005, 16'h4000, 1'b1, 0);

      // R10: CIL on 8001 with E=0
      put(12'h000, mk(0, 3'd2, 12'h500));
      put(12'h001, I_CIL);
      put(12'h002, I_HLT);
      run_prog("R10 rotate left", 12'h003, 16'h0002, 1'b1, 0);

      // R11: nothing moves while halted
      fpc = pc_o;
      fac = ac_o;
      fe  = e_o;
      repeat (20) @(negedge clk);
      chk("R11", "PC frozen", int'(pc_o), int'(fpc));
      chk("R11", "AC frozen", int'(ac_o), int'(fac));
      chk("R11", "E frozen", int'(e_o), int'(fe));
      chk("R11", "halt held", int'(halt_o), 1);

      chk("R11", "unconsumed expectations", sb.size(), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule